// File: doc/BRIEF.md
# Trace Resynchronisation Interval Scheduler

This block decides when a trace encoder should emit a synchronisation packet, so that a decoder that joins the stream late, or loses its place, can lock on again. It keeps a running count of either clock cycles or emitted trace packets. The source is chosen by a two-bit mode input. When the count completes a programmed interval, the block raises a single-cycle request and starts counting again from zero.

The block counts only while tracing is active. Dropping the tracing flag clears the count, so every trace session starts a fresh interval. The interval is taken from the configuration input only while tracing is idle and is then held for the whole session. After reset the held interval is 128, and that value stays in force if tracing is already active when reset is released. Building the sync packet itself is the encoder's job.

Top module: `trace_resync_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sync_req` is low.
- R2: With `cfg_mode` = 2 (cycle counting) and interval N, `sync_req` goes high for one cycle after every N clock edges at which `trace_on` is high. The first request follows the Nth such edge after tracing starts, and is visible in the cycle that follows that edge.
- R3: With `cfg_mode` = 3 (packet counting) and interval N, `sync_req` goes high in the cycle after the edge that samples the Nth `pkt_strobe` pulse. Edges without a strobe do not advance the count.
- R4: With `cfg_mode` = 0 (off) or `cfg_mode` = 1 (reserved, treated as off), `sync_req` never goes high, and the count is held at zero.
- R5: No counting happens while `trace_on` is low. Any edge that samples `trace_on` low clears the count, so a request needs N counted events after tracing restarts.
- R6: An interval value of 0 behaves as an interval of 1.
- R7: The held interval loads from `cfg_interval` at every edge where `trace_on` is low, and is kept unchanged while `trace_on` stays high. Reset sets it to 128.
- R8: After each request the count restarts from zero, so in steady cycle counting the requests are exactly N cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_on | input | 1 | Tracing is active |
| pkt_strobe | input | 1 | One trace packet was emitted this cycle |
| cfg_mode | input | 2 | 0 off, 1 reserved (off), 2 count cycles, 3 count packets |
| cfg_interval | input | 24 | Number of counted events between requests |
| sync_req | output | 1 | One-cycle request for a synchronisation packet |

## Verification
`sync_req` is registered. The counted event that completes an interval is sampled at a rising edge, and the request is visible during the following cycle. A change to `trace_on` or `cfg_interval` also takes effect at the next rising edge. The bench drives all inputs at the falling edge and samples `sync_req` at the next falling edge. A reference model, updated at the rising edge from the requirements, predicts the output for exactly that sample. Directed phases count pulses over windows that end one falling edge after the last qualifying rising edge. The first-request test counts falling edges from reset release and expects the first pulse at edge 128.

// File: rtl/resync_pkg.sv
package resync_pkg;
  // Mode encodings; the values are part of the configuration contract
  typedef enum logic [1:0] {
    RSY_OFF     = 2'd0,
    RSY_RSVD    = 2'd1,
    RSY_CYCLES  = 2'd2,
    RSY_PACKETS = 2'd3
  } rsy_mode_e;

  localparam int unsigned RSY_INTERVAL_W   = 24;
  localparam int unsigned RSY_INTERVAL_RST = 128;
endpackage

// File: rtl/resync_src_sel.sv
module resync_src_sel
  import resync_pkg::*;
(
  input  logic       trace_on,
  input  logic       pkt_strobe,
  input  logic [1:0] mode,
  output logic       count_en,
  output logic       tick
);
  rsy_mode_e mode_e;

  always_comb begin
    mode_e   = rsy_mode_e'(mode);
    count_en = 1'b0;
    tick     = 1'b0;
    unique case (mode_e)
      RSY_CYCLES: begin
        count_en = trace_on;
        tick     = trace_on;
      end
      RSY_PACKETS: begin
        count_en = trace_on;
        tick     = trace_on & pkt_strobe;
      end
      default: begin
        count_en = 1'b0;
        tick     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/resync_thr_shadow.sv
module resync_thr_shadow #(
  parameter int unsigned W       = 24,
  parameter int unsigned RST_VAL = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trace_on,
  input  logic [W-1:0] cfg_interval,
  output logic [W-1:0] thr_q,
  output logic [W-1:0] thr_eff
);
  localparam logic [W-1:0] RST_THR = W'(RST_VAL);
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic         thr_en;
  logic [W-1:0] thr_d;

  always_comb begin
    thr_en = ~trace_on;
    thr_d  = cfg_interval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= RST_THR;
    else if (thr_en) thr_q <= thr_d;
  end

  always_comb begin
    thr_eff = (thr_q == '0) ? ONE : thr_q;
  end
endmodule

// File: rtl/resync_counter.sv
module resync_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         tick,
  input  logic [W-1:0] thr_eff,
  output logic [W-1:0] cnt_q,
  output logic         sync_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_inc;
  logic [W-1:0] cnt_d;
  logic         sync_d;
  logic         hit;

  always_comb begin
    cnt_inc = cnt_q + ONE;
    hit     = tick && (cnt_inc >= thr_eff);
    sync_d  = count_en && hit;
    if (!count_en)  cnt_d = '0;
    else if (hit)   cnt_d = '0;
    else if (tick)  cnt_d = cnt_inc;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/trace_resync_sched.sv
module trace_resync_sched
  import resync_pkg::*;
#(
  parameter int unsigned INTERVAL_W   = RSY_INTERVAL_W,
  parameter int unsigned INTERVAL_RST = RSY_INTERVAL_RST
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trace_on,
  input  logic                  pkt_strobe,
  input  logic [1:0]            cfg_mode,
  input  logic [INTERVAL_W-1:0] cfg_interval,
  output logic                  sync_req
);
  logic                  count_en;
  logic                  tick;
  logic [INTERVAL_W-1:0] thr_q;
  logic [INTERVAL_W-1:0] thr_eff;
  logic [INTERVAL_W-1:0] cnt_q;

  resync_src_sel u_src (
    .trace_on   (trace_on),
    .pkt_strobe (pkt_strobe),
    .mode       (cfg_mode),
    .count_en   (count_en),
    .tick       (tick)
  );

  resync_thr_shadow #(.W(INTERVAL_W), .RST_VAL(INTERVAL_RST)) u_thr (
    .clk          (clk),
    .rst_n        (rst_n),
    .trace_on     (trace_on),
    .cfg_interval (cfg_interval),
    .thr_q        (thr_q),
    .thr_eff      (thr_eff)
  );

  resync_counter #(.W(INTERVAL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .tick     (tick),
    .thr_eff  (thr_eff),
    .cnt_q    (cnt_q),
    .sync_q   (sync_req)
  );
endmodule

// File: rtl/trace_resync_sched_chk.sv
module trace_resync_sched_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         trace_on,
  input logic         pkt_strobe,
  input logic [1:0]   cfg_mode,
  input logic         sync_req,
  input logic [W-1:0] thr_q,
  input logic [W-1:0] thr_eff,
  input logic [W-1:0] cnt_q
);
  // R5
  sync_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> $past(trace_on));

  // R4
  sync_needs_count_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> $past(cfg_mode[1]));

  // R3
  pkt_mode_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && ($past(cfg_mode) == 2'd3)) |-> $past(pkt_strobe));

  // R7
  thr_held_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trace_on) |-> $stable(thr_q));

  // R8
  count_below_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < thr_eff);

  // R6
  eff_interval_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_eff != '0);
endmodule

bind trace_resync_sched trace_resync_sched_chk #(.W(INTERVAL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trace_on   (trace_on),
  .pkt_strobe (pkt_strobe),
  .cfg_mode   (cfg_mode),
  .sync_req   (sync_req),
  .thr_q      (thr_q),
  .thr_eff    (thr_eff),
  .cnt_q      (cnt_q)
);

// File: tb/trace_resync_sched_tb.sv
module trace_resync_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_on = 1'b0;
  logic        pkt_strobe = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [23:0] cfg_interval = 24'd0;
  logic        sync_req;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    model_on = 1'b0;

  // reference model state
  logic [23:0] m_thr;
  int          m_cnt;
  bit          m_sync;

  trace_resync_sched u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .trace_on     (trace_on),
    .pkt_strobe   (pkt_strobe),
    .cfg_mode     (cfg_mode),
    .cfg_interval (cfg_interval),
    .sync_req     (sync_req)
  );

  always #4 clk = ~clk;

  function automatic int eff_interval(logic [23:0] t);
    return (t == 24'd0) ? 1 : int'(t);
  endfunction

  function automatic bit counts_event(logic on, logic [1:0] md, logic pk);
    return on && ((md == 2'd2) || (md == 2'd3 && pk));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr  <= 24'd128;
      m_cnt  <= 0;
      m_sync <= 1'b0;
    end else begin
      m_sync <= 1'b0;
      if (!(trace_on && cfg_mode[1])) m_cnt <= 0;
      else if (counts_event(trace_on, cfg_mode, pkt_strobe)) begin
        if (m_cnt + 1 >= eff_interval(m_thr)) begin
          m_cnt  <= 0;
          m_sync <= 1'b1;
        end else m_cnt <= m_cnt + 1;
      end
      if (!trace_on) m_thr <= cfg_interval;
    end
  end

  task automatic check(string req, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) check(cur_req, sync_req, m_sync);

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic count_pulses(int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sync_req) p++;
    end
  endtask

  task automatic idle_then_start(logic [1:0] md, logic [23:0] iv);
    trace_on = 1'b0;
    cfg_mode = md;
    cfg_interval = iv;
    @(negedge clk);
    trace_on = 1'b1;
  endtask

  initial begin
    int p;
    int first;
    void'($urandom(32'd20240611));
    // R1: reset with tracing already active and a small configured interval
    trace_on = 1'b1;
    cfg_mode = 2'd2;
    cfg_interval = 24'd5;
    repeat (3) @(negedge clk);
    check("R1", sync_req, 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    cur_req = "R7";
    first = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (i == 1) check("R1", sync_req, 0);
      if (sync_req && first == 0) first = i;
    end
    check("R7", first, 128);

    // R2 / R8: interval 4, 20 cycles -> 5 pulses
    cur_req = "R2";
    idle_then_start(2'd2, 24'd4);
    count_pulses(20, p);
    check("R8", p, 5);

    // R3: interval 3, six single strobes -> 2 pulses
    cur_req = "R3";
    idle_then_start(2'd3, 24'd3);
    p = 0;
    for (int i = 0; i < 20; i++) begin
      pkt_strobe = (i % 3 == 0) && (i < 18);
      @(negedge clk);
      if (sync_req) p++;
    end
    pkt_strobe = 1'b0;
    check("R3", p, 2);

    // R4: off and reserved modes never request
    cur_req = "R4";
    pkt_strobe = 1'b1;
    idle_then_start(2'd0, 24'd1);
    count_pulses(40, p);
    check("R4", p, 0);
    idle_then_start(2'd1, 24'd1);
    count_pulses(40, p);
    check("R4", p, 0);
    pkt_strobe = 1'b0;

    // R6: interval 0 acts as 1
    cur_req = "R6";
    idle_then_start(2'd2, 24'd0);
    count_pulses(10, p);
    check("R6", p, 10);
    idle_then_start(2'd3, 24'd0);
    p = 0;
    for (int i = 0; i < 9; i++) begin
      pkt_strobe = (i % 2 == 0) && (i < 8);
      @(negedge clk);
      if (sync_req) p++;
    end
    pkt_strobe = 1'b0;
    check("R6", p, 4);

    // R7: interval held while tracing
    cur_req = "R7";
    idle_then_start(2'd2, 24'd6);
    repeat (3) @(negedge clk);
    cfg_interval = 24'd2;
    count_pulses(15, p);
    check("R7", p, 3);

    // R5: idle clears count; no counting while idle
    cur_req = "R5";
    idle_then_start(2'd2, 24'd5);
    repeat (3) @(negedge clk);
    trace_on = 1'b0;
    @(negedge clk);
    trace_on = 1'b1;
    count_pulses(4, p);
    check("R5", p, 0);
    @(negedge clk);
    check("R5", sync_req, 1);
    trace_on = 1'b0;
    count_pulses(20, p);
    check("R5", p, 0);

    // random mix across modes
    cur_req = "R3 random";
    for (int i = 0; i < 4000; i++) begin
      pkt_strobe = $urandom % 2;
      if ($urandom % 16 == 0) trace_on = ~trace_on;
      if ($urandom % 64 == 0) cfg_mode = 2'($urandom % 4);
      if ($urandom % 8 == 0) cfg_interval = 24'($urandom % 6);
      @(negedge clk);
    end
    model_on = 1'b0;
    finish_run();
  end
endmodule